// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits between a transmit controller and the line driver and guards the shared medium against a controller that never stops sending. It counts how many consecutive clock cycles the transmit-enable input stays high. If one transmission reaches the allowed maximum, the block cuts the driver off and raises an active-high jabber flag. It then holds the driver off for a fixed penalty period.

When the penalty period ends, the driver is re-enabled only if the controller has dropped transmit-enable. If the controller is still asserting it, the block keeps the driver off and keeps the flag raised until transmit-enable is seen low. While the driver is off, the outgoing data bus is forced to all zeros.

Both time limits are parameters counted in clock cycles. A deployment sets them to about 25 ms and 600 ms of its own clock. A bench scales them down to a few cycles. The driver gate and the data gate are combinational from the current inputs and the registered state, so a healthy transmission reaches the driver with no added latency.

Top module: `tx_jabber_guard`

## Requirements
- R1: While rst_ni is low, jabber_o is 0 and the block is idle: with tx_en_i low, drv_en_o is 0 and tx_data_o is all zeros.
- R2: While not jabbering, drv_en_o equals tx_en_i, and tx_data_o equals tx_data_i when tx_en_i is 1 and is zero otherwise, in the same cycle.
- R3: If tx_en_i is sampled high on MAX_TX_CYCLES consecutive rising edges, then from the cycle after the last of those edges jabber_o is 1 and drv_en_o is 0.
- R4: A run of at most MAX_TX_CYCLES-1 high samples never raises jabber_o. A single low sample restarts the run count from zero.
- R5: The penalty lasts exactly PENALTY_CYCLES cycles. If tx_en_i is sampled low on the last penalty edge, drv_en_o follows tx_en_i again in the very next cycle.
- R6: If tx_en_i is still high on the last penalty edge, the driver stays off and jabber_o stays 1 until tx_en_i is sampled low. The block is released in the cycle after that sample.
- R7: Whenever the driver is off because of jabber, tx_data_o is all zeros, whatever tx_en_i and tx_data_i are.
- R8: jabber_o stays 1 in every cycle in which the driver is held off, and drv_en_o is never 1 while jabber_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock that times both windows |
| rst_ni | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmit enable from the controller |
| tx_data_i | input | DATA_W | Transmit data from the controller |
| drv_en_o | output | 1 | Enable gate for the line driver |
| tx_data_o | output | DATA_W | Transmit data to the driver, all zeros when gated |
| jabber_o | output | 1 | Active-high jabber status |

## Verification
Two events can fall in the same cycle: the last penalty edge and the controller dropping transmit-enable. The bench provokes this by lowering the enable exactly on the final penalty sample and expects the driver to be released in the next cycle. It then repeats the case with the enable dropped one sample later and expects exactly one extra blocked cycle. The other collision is a transmission that ends one sample before the timeout. The bench drives bursts of MAX_TX_CYCLES-1 samples separated by a single low cycle and expects no trip; a burst one sample longer must trip.

// File: rtl/tx_jabber_pkg.sv
package tx_jabber_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SEND      = 2'd1,
        ST_HOLD      = 2'd2,
        ST_WAIT_DROP = 2'd3
    } guard_state_e;

    typedef struct packed {
        guard_state_e state;
    } guard_regs_t;

endpackage

// File: rtl/tx_jabber_cycle_counter.sv
module tx_jabber_cycle_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tx_jabber_gate.sv
module tx_jabber_gate #(
    parameter int DATA_W = 4
) (
    input  logic              allow_i,
    input  logic              tx_en_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              drv_en_o,
    output logic [DATA_W-1:0] tx_data_o
);

    logic pass;

    assign pass     = allow_i & tx_en_i;
    assign drv_en_o = pass;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign tx_data_o[b] = tx_data_i[b] & pass;
    end

endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard
    import tx_jabber_pkg::*;
#(
    parameter int MAX_TX_CYCLES  = 250000,
    parameter int PENALTY_CYCLES = 6000000,
    parameter int DATA_W         = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tx_en_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              drv_en_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              jabber_o
);

    localparam int LONGEST = (MAX_TX_CYCLES > PENALTY_CYCLES) ? MAX_TX_CYCLES : PENALTY_CYCLES;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(MAX_TX_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(PENALTY_CYCLES - 1);

    guard_regs_t      regs_d;
    guard_regs_t      regs_q;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt;
    logic             allow;

    tx_jabber_cycle_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .cnt_o  (cnt)
    );

    // Next-state logic: one shared counter times either the send run or the penalty.
    always_comb begin
        regs_d  = regs_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (regs_q.state)
            ST_IDLE, ST_SEND: begin
                if (!tx_en_i) begin
                    regs_d.state = ST_IDLE;
                    cnt_clr      = 1'b1;
                end else if (cnt == TX_LAST) begin
                    regs_d.state = ST_HOLD;
                    cnt_clr      = 1'b1;
                end else begin
                    regs_d.state = ST_SEND;
                    cnt_inc      = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt == HOLD_LAST) begin
                    regs_d.state = tx_en_i ? ST_WAIT_DROP : ST_IDLE;
                    cnt_clr      = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_WAIT_DROP: begin
                cnt_clr = 1'b1;
                if (!tx_en_i) begin
                    regs_d.state = ST_IDLE;
                end
            end
            default: begin
                regs_d.state = ST_IDLE;
                cnt_clr      = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q.state <= ST_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign allow    = (regs_q.state == ST_IDLE) || (regs_q.state == ST_SEND);
    assign jabber_o = !allow;

    tx_jabber_gate #(
        .DATA_W (DATA_W)
    ) u_gate (
        .allow_i   (allow),
        .tx_en_i   (tx_en_i),
        .tx_data_i (tx_data_i),
        .drv_en_o  (drv_en_o),
        .tx_data_o (tx_data_o)
    );

endmodule

// File: rtl/tx_jabber_guard_chk.sv
module tx_jabber_guard_chk #(
    parameter int MAX_TX_CYCLES  = 250000,
    parameter int PENALTY_CYCLES = 6000000,
    parameter int DATA_W         = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tx_en_i,
    input logic [DATA_W-1:0] tx_data_i,
    input logic              drv_en_o,
    input logic [DATA_W-1:0] tx_data_o,
    input logic              jabber_o
);

    int unsigned send_run_q;
    int unsigned block_run_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni || !tx_en_i || jabber_o) begin
            send_run_q <= 0;
        end else if (send_run_q != 32'hFFFF_FFFF) begin
            send_run_q <= send_run_q + 1;
        end
        if (!rst_ni || !jabber_o) begin
            block_run_q <= 0;
        end else if (block_run_q != 32'hFFFF_FFFF) begin
            block_run_q <= block_run_q + 1;
        end
    end

    // R8: the driver is never enabled while the flag is raised
    assert_drv_off_in_jabber_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        jabber_o |-> !drv_en_o);

    // R7: gated data is idle whenever the driver is off
    assert_data_idle_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drv_en_o |-> (tx_data_o == '0));

    // R3, R4: a trip follows exactly MAX_TX_CYCLES high samples
    assert_trip_after_full_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(jabber_o) |-> (send_run_q == MAX_TX_CYCLES));

    // R5: the flag never drops before the penalty has run its full length
    assert_penalty_length_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(jabber_o) |-> (block_run_q >= PENALTY_CYCLES));

    // R6: release only follows a low sample of the enable
    assert_release_needs_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(jabber_o) |-> !$past(tx_en_i));

    // R2: without jabber the driver gate follows the enable
    assert_pass_through_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!jabber_o && tx_en_i) |-> (drv_en_o && (tx_data_o == tx_data_i)));

endmodule

bind tx_jabber_guard tx_jabber_guard_chk #(
    .MAX_TX_CYCLES  (MAX_TX_CYCLES),
    .PENALTY_CYCLES (PENALTY_CYCLES),
    .DATA_W         (DATA_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_en_i   (tx_en_i),
    .tx_data_i (tx_data_i),
    .drv_en_o  (drv_en_o),
    .tx_data_o (tx_data_o),
    .jabber_o  (jabber_o)
);

// File: tb/tx_jabber_guard_tb_top.sv
module tx_jabber_guard_tb_top;

    localparam int CLK_P = 10;
    localparam int MAXC  = 8;
    localparam int PENC  = 20;
    localparam int DW    = 4;

    logic          clk     = 1'b0;
    logic          rst_n   = 1'b0;
    logic          tx_en   = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          drv;
    logic [DW-1:0] data_o;
    logic          jab;

    always #(CLK_P/2) clk = ~clk;

    tx_jabber_guard #(
        .MAX_TX_CYCLES  (MAXC),
        .PENALTY_CYCLES (PENC),
        .DATA_W         (DW)
    ) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tx_en_i   (tx_en),
        .tx_data_i (tx_data),
        .drv_en_o  (drv),
        .tx_data_o (data_o),
        .jabber_o  (jab)
    );

    typedef struct {
        logic          drv;
        logic [DW-1:0] data;
        logic          jab;
        string         req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    // reference model: 0 open, 1 penalty, 2 waiting for the enable to drop
    int   m_st  = 0;
    int   m_cnt = 0;

    task automatic step(input logic en, input logic [DW-1:0] d, input string req);
        exp_t e;
        logic open;
        @(negedge clk);
        tx_en   = en;
        tx_data = d;
        open    = (m_st == 0);
        e.drv   = en & open;
        e.data  = (en & open) ? d : '0;
        e.jab   = !open;
        e.req   = req;
        q.push_back(e);
        if (rst_n) begin
            if (m_st == 0) begin
                if (!en) m_cnt = 0;
                else if (m_cnt == MAXC - 1) begin m_st = 1; m_cnt = 0; end
                else m_cnt++;
            end else if (m_st == 1) begin
                if (m_cnt == PENC - 1) begin m_cnt = 0; m_st = en ? 2 : 0; end
                else m_cnt++;
            end else begin
                if (!en) m_st = 0;
            end
        end
    endtask

    // monitor: one expected item per cycle, compared a quarter period after the drive
    always begin
        exp_t e;
        @(negedge clk);
        #(CLK_P/4);
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (drv !== e.drv || data_o !== e.data || jab !== e.jab) begin
                errors++;
                $display("FAIL %s: drv=%0b data=%h jab=%0b expected drv=%0b data=%h jab=%0b",
                         e.req, drv, data_o, jab, e.drv, e.data, e.jab);
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1'b0, 4'h0, "R1");
        step(1'b0, 4'h9, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: pass-through with varied data, run kept under the limit
        for (int i = 0; i < MAXC - 1; i++) step(1'b1, DW'(i * 3 + 1), "R2");
        // R4: one low sample restarts the run; another near-limit burst must not trip
        step(1'b0, 4'hA, "R4");
        for (int i = 0; i < MAXC - 1; i++) step(1'b1, DW'(15 - i), "R4");
        step(1'b0, 4'h0, "R4");
        step(1'b0, 4'h0, "R4");

        // R3: full-length run trips
        for (int i = 0; i < MAXC; i++) step(1'b1, 4'h5, "R3");
        // R7/R8: penalty with the enable held high and data active
        for (int i = 0; i < PENC; i++) step(1'b1, 4'hF, "R7");
        // R6: enable still high after the penalty keeps the block waiting
        for (int i = 0; i < 3; i++) step(1'b1, 4'h6, "R6");
        step(1'b0, 4'h6, "R6");
        step(1'b1, 4'h3, "R6");
        step(1'b0, 4'h0, "R6");

        // R5: enable dropped during the penalty, release exactly at its end
        for (int i = 0; i < MAXC; i++) step(1'b1, 4'hC, "R3");
        for (int i = 0; i < PENC; i++) step(1'b0, 4'hC, "R5");
        step(1'b1, 4'h7, "R5");
        step(1'b0, 4'h0, "R5");

        // R6: drop coincides with the last penalty sample
        for (int i = 0; i < MAXC; i++) step(1'b1, 4'h2, "R3");
        for (int i = 0; i < PENC - 1; i++) step(1'b1, 4'h2, "R8");
        step(1'b0, 4'h2, "R6");
        step(1'b1, 4'hB, "R6");
        step(1'b0, 4'h0, "R6");

        // R6: drop one sample after the penalty costs exactly one blocked cycle
        for (int i = 0; i < MAXC; i++) step(1'b1, 4'h4, "R3");
        for (int i = 0; i < PENC; i++) step(1'b1, 4'h4, "R8");
        step(1'b0, 4'h4, "R6");
        step(1'b1, 4'hE, "R6");
        step(1'b0, 4'h0, "R2");

        step(1'b0, 4'h0, "R2");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule